// File: doc/BRIEF.md
# Transmit Sample Buffer with Underflow Replay and Fatal Line Forcing

This block sits between a system-side producer of audio samples and the interface side of a pulse-width-modulated output channel. The producer pushes samples into a 64-entry first-in first-out store. The consumer pulls them out one at a time, and each pulled sample is held on a registered output. When the consumer pulls from an empty store, the output keeps showing the last sample it delivered, so the line carries a repeated value rather than garbage.

An interrupt-cause vector records four events. Each flag stays set until software clears it by writing a one to that bit.
- A trigger flag is raised while the fill level sits at or below a programmable threshold.
- An overflow flag is raised by a write to a full store.
- An underflow flag is raised by a read from an empty store.
- An interface-starvation flag is raised when the interface wants a sample and none is ready.

Starvation is also fatal. It latches a state that drives every positive and negative line output low. Clearing the flag does not end that state; only dropping the channel enable does. Dropping the enable also empties the store.

Top module: `pcm_tx_sample_buf`

## Requirements
- R1: The store holds up to 64 samples and `fill` reports the occupancy, 0 for empty and 64 for full. An accepted write adds one and an accepted read removes one, both at the same clock edge.
- R2: Samples come out in the order they were accepted. A read accepted at an edge presents the oldest stored sample on `rd_data` from that edge on.
- R3: A write while `fill` is 64 is dropped, leaving contents and `fill` unchanged, and sets cause bit 1.
- R4: A read while `fill` is 0 leaves `rd_data` at the previously delivered sample and sets cause bit 2.
- R5: At every edge where the channel is enabled and `fill` is less than or equal to `trig_level`, cause bit 0 is set.
- R6: At an edge where the channel is enabled, `if_slot` is 1 and `smp_valid` is 0, cause bit 8 is set and the fatal state is entered.
- R7: While the fatal state holds, both `line_p` bits and both `line_n` bits are 0 from the edge that entered it. Otherwise they follow `line_p_in` and `line_n_in`.
- R8: A `clr_we` pulse clears every cause bit whose `clr_mask` bit is 1, unless the same bit is set at that edge, in which case the set wins. Clearing bit 8 does not leave the fatal state. Cause bits 3 to 7 always read 0.
- R9: At an edge with `chan_en` at 0, the store empties (`fill` becomes 0) and the fatal state is left. While the channel is disabled, writes, reads and slot requests have no effect and set no flag, and `rd_data` holds its value.
- R10: After reset, `cause` is 0, `fill` is 0, `rd_data` is 0 and the line outputs follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; 0 flushes the store and leaves the fatal state |
| wr_en | input | 1 | Producer write request |
| wr_data | input | 16 | Sample to write |
| rd_en | input | 1 | Consumer read request |
| rd_data | output | 16 | Last delivered sample |
| fill | output | 7 | Occupancy, 0 to 64 |
| trig_level | input | 7 | Threshold for the trigger flag |
| if_slot | input | 1 | Interface needs a modulated sample this cycle |
| smp_valid | input | 1 | A modulated sample is ready for the interface |
| line_p_in | input | 2 | Positive line drive from the modulator |
| line_n_in | input | 2 | Negative line drive from the modulator |
| line_p | output | 2 | Positive line outputs after forcing |
| line_n | output | 2 | Negative line outputs after forcing |
| clr_we | input | 1 | Write strobe for clearing cause bits |
| clr_mask | input | 9 | Cause bits to clear where 1 |
| cause | output | 9 | Interrupt-cause flags: bit 0 trigger, 1 overflow, 2 underflow, 8 interface starvation |

## Verification
A pointer or count that goes wrong shows up within one cycle as a `fill` mismatch. A pointer out of step with the count shows up as a wrong `rd_data` on the next accepted read, because samples carry distinct values. A flag register that misses a set or a clear differs from the expected vector at the very edge of the event. A fatal latch that releases early lets the line inputs through in the cycle it clears, so the line outputs give it away immediately. The random mix spends long stretches near full and near empty and keeps toggling the enable, so these edges are exercised many times.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   localparam int CAUSE_W = 9;
   localparam int CB_TRIG = 0;
   localparam int CB_OVF  = 1;
   localparam int CB_UDF  = 2;
   localparam int CB_IFU  = 8;
   localparam logic [CAUSE_W-1:0] CAUSE_USED =
      (CAUSE_W'(1) << CB_TRIG) | (CAUSE_W'(1) << CB_OVF) |
      (CAUSE_W'(1) << CB_UDF)  | (CAUSE_W'(1) << CB_IFU);

   typedef struct packed {
      logic trig;
      logic ovf;
      logic udf;
      logic ifu;
   } sbuf_evt_t;
endpackage

// File: rtl/sbuf_ram.sv
module sbuf_ram #(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 64,
   parameter bit RESET_MEM = 1'b1,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("sbuf_ram: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sbuf_ram: DATA_W must be at least 1");
   end

   if (RESET_MEM) begin : g_rst_mem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (we) begin
            mem_q[waddr] <= wdata;
         end
      end
   end else begin : g_plain_mem
      always_ff @(posedge clk) begin
         if (we) mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
   import sbuf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [CW-1:0]     trig_level,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic [AW-1:0]     mem_raddr,
   output logic [CW-1:0]     fill,
   output logic [DATA_W-1:0] rd_data,
   output logic              evt_trig,
   output logic              evt_ovf,
   output logic              evt_udf
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

   logic [AW-1:0]     wp_q, rp_q;
   logic [CW-1:0]     cnt_q;
   logic [DATA_W-1:0] out_q;
   logic              is_full, is_empty, wr_ok, rd_ok;

   if (DEPTH < 2) begin : g_bad_depth
      $error("sbuf_ctrl: DEPTH must be at least 2");
   end

   function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
      return (p == LAST_PTR) ? '0 : p + AW'(1);
   endfunction

   assign is_full  = (cnt_q == FULL_CNT);
   assign is_empty = (cnt_q == '0);
   assign wr_ok    = chan_en & wr_en & ~is_full;
   assign rd_ok    = chan_en & rd_en & ~is_empty;

   assign evt_ovf  = chan_en & wr_en & is_full;
   assign evt_udf  = chan_en & rd_en & is_empty;
   assign evt_trig = chan_en & (cnt_q <= trig_level);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         out_q <= '0;
      end else if (!chan_en) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_ok) wp_q <= ptr_inc(wp_q);
         if (rd_ok) begin
            rp_q  <= ptr_inc(rp_q);
            out_q <= mem_rdata;
         end
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign mem_we    = wr_ok;
   assign mem_waddr = wp_q;
   assign mem_raddr = rp_q;
   assign fill      = cnt_q;
   assign rd_data   = out_q;

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_CNT); // R1
   AST_FULL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && wr_en && !rd_en && fill == FULL_CNT) |=> fill == FULL_CNT); // R3
   AST_EMPTY_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && rd_en && fill == '0) |=> $stable(rd_data)); // R4
   AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> fill == '0); // R9
endmodule

// File: rtl/sbuf_cause.sv
module sbuf_cause
   import sbuf_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  sbuf_evt_t          evt,
   input  logic               clr_we,
   input  logic [CAUSE_W-1:0] clr_mask,
   output logic [CAUSE_W-1:0] cause
);
   logic [CAUSE_W-1:0] set_vec;
   logic               unused_clr;

   always_comb begin
      set_vec          = '0;
      set_vec[CB_TRIG] = evt.trig;
      set_vec[CB_OVF]  = evt.ovf;
      set_vec[CB_UDF]  = evt.udf;
      set_vec[CB_IFU]  = evt.ifu;
   end

   assign unused_clr = ^(clr_mask & ~CAUSE_USED) ^ ^(set_vec & ~CAUSE_USED);

   for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
      if (CAUSE_USED[i]) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set_vec[i] | (flag_q & ~(clr_we & clr_mask[i]));
         end
         assign cause[i] = flag_q;

         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i] && !set_vec[i]) |=> !cause[i]); // R8
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> cause[i]); // R8
      end else begin : g_zero
         assign cause[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sbuf_line_gate.sv
module sbuf_line_gate #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             if_slot,
   input  logic             smp_valid,
   input  logic [LANES-1:0] line_p_in,
   input  logic [LANES-1:0] line_n_in,
   output logic [LANES-1:0] line_p,
   output logic [LANES-1:0] line_n,
   output logic             evt_ifu
);
   logic fatal_q;

   if (LANES < 1) begin : g_bad_lanes
      $error("sbuf_line_gate: LANES must be at least 1");
   end

   assign evt_ifu = chan_en & if_slot & ~smp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fatal_q <= 1'b0;
      else if (!chan_en) fatal_q <= 1'b0;
      else if (evt_ifu)  fatal_q <= 1'b1;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign line_p[l] = line_p_in[l] & ~fatal_q;
      assign line_n[l] = line_n_in[l] & ~fatal_q;
   end

   AST_STARVE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ifu |=> (line_p == '0 && line_n == '0)); // R7
   AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal_q && chan_en) |=> fatal_q); // R8
   AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> (line_p == line_p_in && line_n == line_n_in)); // R9
endmodule

// File: rtl/pcm_tx_sample_buf.sv
module pcm_tx_sample_buf
   import sbuf_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 64,
   parameter int LANES     = 2,
   parameter bit RESET_MEM = 1'b1,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chan_en,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   output logic [DATA_W-1:0]  rd_data,
   output logic [CW-1:0]      fill,
   input  logic [CW-1:0]      trig_level,
   input  logic               if_slot,
   input  logic               smp_valid,
   input  logic [LANES-1:0]   line_p_in,
   input  logic [LANES-1:0]   line_n_in,
   output logic [LANES-1:0]   line_p,
   output logic [LANES-1:0]   line_n,
   input  logic               clr_we,
   input  logic [CAUSE_W-1:0] clr_mask,
   output logic [CAUSE_W-1:0] cause
);
   logic              mem_we;
   logic [AW-1:0]     mem_waddr, mem_raddr;
   logic [DATA_W-1:0] mem_rdata;
   sbuf_evt_t         evt;

   sbuf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RESET_MEM(RESET_MEM)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
      .wdata(wr_data), .raddr(mem_raddr), .rdata(mem_rdata)
   );

   sbuf_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en), .rd_en(rd_en),
      .trig_level(trig_level), .mem_rdata(mem_rdata), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .mem_raddr(mem_raddr), .fill(fill), .rd_data(rd_data),
      .evt_trig(evt.trig), .evt_ovf(evt.ovf), .evt_udf(evt.udf)
   );

   sbuf_line_gate #(.LANES(LANES)) u_gate (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .if_slot(if_slot),
      .smp_valid(smp_valid), .line_p_in(line_p_in), .line_n_in(line_n_in),
      .line_p(line_p), .line_n(line_n), .evt_ifu(evt.ifu)
   );

   sbuf_cause u_cause (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr_we(clr_we),
      .clr_mask(clr_mask), .cause(cause)
   );

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cause[7:3] == '0); // R8
endmodule

// File: tb/pcm_tx_sample_buf_bench.sv
module pcm_tx_sample_buf_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [6:0]  fill;
   logic [6:0]  trig_level = '0;
   logic        if_slot = 1'b0, smp_valid = 1'b1;
   logic [1:0]  line_p_in = '0, line_n_in = '0, line_p, line_n;
   logic        clr_we = 1'b0;
   logic [8:0]  clr_mask = '0;
   logic [8:0]  cause;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] mq[$];
   logic [15:0] m_rd = '0;
   logic [8:0]  m_cause = '0;
   bit          m_fatal = 1'b0;
   logic [15:0] seq_val = 16'h1000;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_tx_sample_buf u_pcm_tx_sample_buf (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .fill(fill), .trig_level(trig_level),
      .if_slot(if_slot), .smp_valid(smp_valid), .line_p_in(line_p_in),
      .line_n_in(line_n_in), .line_p(line_p), .line_n(line_n), .clr_we(clr_we),
      .clr_mask(clr_mask), .cause(cause)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [8:0] next_cause(input logic [8:0] cur, input logic [8:0] sets,
                                             input logic cwe, input logic [8:0] cm);
      return (cur & ~(cwe ? cm : 9'h0)) | sets;
   endfunction

   // One cycle: apply inputs, predict, clock, compare.
   task automatic step(input logic en, input logic wr, input logic [15:0] wd,
                       input logic rd, input logic slot, input logic valid,
                       input logic cwe, input logic [8:0] cm, input logic [6:0] lvl,
                       input logic [1:0] lp, input logic [1:0] ln);
      logic [8:0] sets;
      int cnt;
      chan_en = en; wr_en = wr; wr_data = wd; rd_en = rd; if_slot = slot;
      smp_valid = valid; clr_we = cwe; clr_mask = cm; trig_level = lvl;
      line_p_in = lp; line_n_in = ln;
      sets = '0;
      cnt = mq.size();
      if (en) begin
         if (cnt <= int'(lvl))      sets[0] = 1'b1;
         if (wr && cnt == DEPTH)    sets[1] = 1'b1;
         if (rd && cnt == 0)        sets[2] = 1'b1;
         if (slot && !valid)        sets[8] = 1'b1;
      end
      m_cause = next_cause(m_cause, sets, cwe, cm);
      if (!en) begin
         mq.delete();
         m_fatal = 1'b0;
      end else begin
         if (rd && cnt > 0) m_rd = mq.pop_front();
         if (wr && cnt < DEPTH) mq.push_back(wd);
         if (slot && !valid) m_fatal = 1'b1;
      end
      @(posedge clk);
      #1;
      check("R1 fill", 32'(fill), 32'(mq.size()));
      check("R2/R4 rd_data", 32'(rd_data), 32'(m_rd));
      check("R5 cause bit0", 32'(cause[0]), 32'(m_cause[0]));
      check("R3 cause bit1", 32'(cause[1]), 32'(m_cause[1]));
      check("R4 cause bit2", 32'(cause[2]), 32'(m_cause[2]));
      check("R6 cause bit8", 32'(cause[8]), 32'(m_cause[8]));
      check("R8 reserved bits", 32'(cause[7:3]), 32'd0);
      check("R7 line_p", 32'(line_p), m_fatal ? 32'd0 : 32'(lp));
      check("R7 line_n", 32'(line_n), m_fatal ? 32'd0 : 32'(ln));
   endtask

   task automatic idle(input logic en);
      step(en, 0, 16'h0, 0, 0, 1, 0, 9'h0, 7'd0, 2'b11, 2'b11);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      line_p_in = 2'b10; line_n_in = 2'b01;
      #(CLK_PERIOD * 2 + 3);
      // R10: reset state
      check("R10 cause", 32'(cause), 32'd0);
      check("R10 fill", 32'(fill), 32'd0);
      check("R10 rd_data", 32'(rd_data), 32'd0);
      check("R10 line_p", 32'(line_p), 32'(2'b10));
      check("R10 line_n", 32'(line_n), 32'(2'b01));
      rst_n = 1'b1;
      idle(0);

      // R1/R3: fill to full, then an extra write is dropped
      for (int i = 0; i < DEPTH; i++) begin
         step(1, 1, seq_val, 0, 0, 1, 0, 9'h0, 7'd0, 2'b11, 2'b11);
         seq_val++;
      end
      check("R1 full count", 32'(fill), 32'd64);
      step(1, 1, 16'hDEAD, 0, 0, 1, 0, 9'h0, 7'd0, 2'b11, 2'b11);
      check("R3 dropped write keeps fill", 32'(fill), 32'd64);
      check("R3 overflow flag", 32'(cause[1]), 32'd1);

      // R2: drain in order, then R4 replay on empty
      for (int i = 0; i < DEPTH; i++)
         step(1, 0, 16'h0, 1, 0, 1, 0, 9'h0, 7'd0, 2'b11, 2'b11);
      check("R2 last sample", 32'(rd_data), 32'(seq_val - 16'd1));
      step(1, 0, 16'h0, 1, 0, 1, 0, 9'h0, 7'd0, 2'b11, 2'b11);
      check("R4 replay on empty", 32'(rd_data), 32'(seq_val - 16'd1));
      check("R4 underflow flag", 32'(cause[2]), 32'd1);

      // R8: clear all flags while no event (trigger level 0 at fill 1)
      step(1, 1, 16'h5555, 0, 0, 1, 0, 9'h0, 7'd0, 2'b11, 2'b11);
      step(1, 0, 16'h0, 0, 0, 1, 1, 9'h1FF, 7'd0, 2'b11, 2'b11);
      check("R8 cleared", 32'(cause), 32'd0);

      // R6/R7/R8: starvation, clearing bit 8 keeps lines forced
      step(1, 0, 16'h0, 0, 1, 0, 0, 9'h0, 7'd0, 2'b11, 2'b11);
      check("R6 ifu flag", 32'(cause[8]), 32'd1);
      check("R7 forced low", 32'({line_p, line_n}), 32'd0);
      step(1, 0, 16'h0, 0, 0, 1, 1, 9'h100, 7'd0, 2'b11, 2'b11);
      check("R8 bit8 cleared", 32'(cause[8]), 32'd0);
      check("R8 still forced", 32'({line_p, line_n}), 32'd0);

      // R9: disable flushes and releases; disabled requests ignored
      step(0, 1, 16'h7777, 1, 1, 0, 0, 9'h0, 7'd0, 2'b11, 2'b11);
      check("R9 flushed", 32'(fill), 32'd0);
      check("R9 released", 32'({line_p, line_n}), 32'hF);
      check("R9 no flag while off", 32'(cause), 32'd0);
      check("R9 rd_data held", 32'(rd_data), 32'(seq_val - 16'd1));

      // Random mix
      begin
         logic [6:0] lvl;
         bit pw;
         lvl = 7'd8;
         for (int c = 0; c < 6000; c++) begin
            logic en, w, r, s, v, cw;
            if (c % 400 == 0) begin
               lvl = 7'($urandom_range(0, 64));
               pw = ((c / 400) % 2) == 0;
            end
            en = ($urandom_range(0, 299) != 0);
            w  = pw ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 9) < 3);
            r  = pw ? ($urandom_range(0, 9) < 3) : ($urandom_range(0, 9) < 8);
            s  = ($urandom_range(0, 3) == 0);
            v  = ($urandom_range(0, 499) != 0);
            cw = ($urandom_range(0, 7) == 0);
            step(en, w, 16'($urandom), r, s, v, cw, 9'($urandom),
                 lvl, 2'($urandom), 2'($urandom));
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule